// File: doc/BRIEF.md
# Transactional FIFO with commit and abort

This is a single-clock FIFO with a valid/ready handshake on both sides. Either side can also treat a run of transfers as one transaction. A writer can stream words in and later publish them all at once, or throw them away. A reader can pull words speculatively and later release their storage, or rewind and receive the same words again. Typical uses are a packet buffer that must discard a bad packet already partly written, and a consumer that may need to retry a burst.

Each side keeps two pointers: a working pointer that moves with every transfer, and a committed pointer. A commit copies the working pointer into the committed pointer. An abort copies the committed pointer back into the working pointer. The writer measures free space against the reader's committed pointer. The reader measures available data against the writer's committed pointer. A parameter per side turns the transaction controls off, and that side then behaves as if commit were always high.

Top module: `txn_fifo`

## Requirements
- R1: A word moves on a rising clock edge when valid and ready are both high on that side. `in_ready` is low exactly when `in_used` equals DEPTH. Words leave in the order they were published, and a stalled output word holds its value.
- R2: Words written while `in_commit` is low stay invisible to the reader. `out_valid` and `out_used` do not count them until a commit.
- R3: A one-cycle `in_abort` discards every unpublished word, including a word accepted in that same cycle. If those words had filled the FIFO, `in_ready` is high in the following cycle.
- R4: Raising `in_commit` in the same cycle as a write publishes that word together with the earlier unpublished ones.
- R5: Reads taken while `out_commit` is low free no space: `in_used` does not fall. The FIFO can then show `out_valid` low and `in_ready` low at the same time. A later read commit frees the space.
- R6: `out_abort` rewinds the reader to its last committed position, so the same words are delivered again in the same order.
- R7: When commit and abort are high together on one side, the abort takes effect and the commit is ignored.
- R8: `in_used` counts words written and not yet released by a read commit. `out_used` counts published words not yet read. Both are clog2(DEPTH+1) bits wide, so a completely full FIFO can be shown, and `out_used` never exceeds `in_used`.
- R9: A synchronous reset empties the FIFO: `in_ready` is 1, `out_valid` is 0, and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Writer offers a word |
| in_ready | output | 1 | FIFO can accept a word |
| in_data | input | DW | Word offered by the writer |
| in_commit | input | 1 | Publish all words written so far, including this cycle's |
| in_abort | input | 1 | Discard unpublished words |
| in_used | output | clog2(DEPTH+1) | Occupancy as seen by the writer |
| out_valid | output | 1 | A published word is available |
| out_ready | input | 1 | Reader takes the word |
| out_data | output | DW | Word presented to the reader |
| out_commit | input | 1 | Release all words read so far, including this cycle's |
| out_abort | input | 1 | Rewind the reader to its last committed position |
| out_used | output | clog2(DEPTH+1) | Published words not yet read |

## Verification
The bench builds the block with 16-bit data, DEPTH of 5, and transactions enabled on both sides. Because 5 is not a power of two, the pointers pass through their modulo-2·DEPTH wrap many times. The small depth means full and empty are reached within a few cycles. Directed phases cover each transaction corner. A long random phase then mixes commits and aborts on both sides, so that rewinds happen while the writer is blocked and publishes happen while the reader is mid-transaction.

// File: rtl/txn_fifo.sv
module txn_fifo #(
  parameter int DW     = 16,
  parameter int DEPTH  = 32,
  parameter bit WR_TXN = 1'b1,
  parameter bit RD_TXN = 1'b1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int UW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_commit,
  input  logic          in_abort,
  output logic [UW-1:0] in_used,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic          out_commit,
  input  logic          out_abort,
  output logic [UW-1:0] out_used
);

  localparam int PW   = $clog2(2 * DEPTH);
  localparam int LAST = 2 * DEPTH - 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_work, wr_cmt, rd_work, rd_cmt;
  logic [PW-1:0] wr_next, rd_next;
  logic          push, pop;
  logic          wr_pub, wr_drop, rd_rel, rd_back;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(LAST)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [UW-1:0] span(input logic [PW-1:0] a, input logic [PW-1:0] b);
    logic [PW:0] d;
    d = (a >= b) ? ({1'b0, a} - {1'b0, b})
                 : ({1'b0, a} + (PW+1)'(2 * DEPTH) - {1'b0, b});
    return UW'(d);
  endfunction

  function automatic logic [AW-1:0] slot(input logic [PW-1:0] p);
    return (p >= PW'(DEPTH)) ? AW'(p - PW'(DEPTH)) : AW'(p);
  endfunction

  assign wr_drop = WR_TXN & in_abort;
  assign wr_pub  = ~WR_TXN | in_commit;
  assign rd_back = RD_TXN & out_abort;
  assign rd_rel  = ~RD_TXN | out_commit;

  assign in_used   = span(wr_work, rd_cmt);
  assign out_used  = span(wr_cmt, rd_work);
  assign in_ready  = (in_used != UW'(DEPTH));
  assign out_valid = (rd_work != wr_cmt);
  assign out_data  = mem[slot(rd_work)];

  assign push    = in_valid & in_ready;
  assign pop     = out_valid & out_ready;
  assign wr_next = push ? bump(wr_work) : wr_work;
  assign rd_next = pop  ? bump(rd_work) : rd_work;

  always_ff @(posedge clk) begin
    if (push) mem[slot(wr_work)] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_work <= '0;
      wr_cmt  <= '0;
    end else if (wr_drop) begin
      wr_work <= wr_cmt;
    end else begin
      wr_work <= wr_next;
      if (wr_pub) wr_cmt <= wr_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_work <= '0;
      rd_cmt  <= '0;
    end else if (rd_back) begin
      rd_work <= rd_cmt;
    end else begin
      rd_work <= rd_next;
      if (rd_rel) rd_cmt <= rd_next;
    end
  end

endmodule

// File: rtl/txn_fifo_chk.sv
module txn_fifo_chk #(
  parameter int DEPTH  = 32,
  parameter int DW     = 16,
  parameter bit WR_TXN = 1'b1,
  parameter bit RD_TXN = 1'b1,
  localparam int UW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          in_commit,
  input logic          in_abort,
  input logic [UW-1:0] in_used,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_commit,
  input logic          out_abort,
  input logic [UW-1:0] out_used
);

  p_counts_r8: assert property (@(posedge clk) disable iff (rst)
    (in_used <= UW'(DEPTH)) && (out_used <= in_used));

  p_full_blocks_r1: assert property (@(posedge clk) disable iff (rst)
    (in_used == UW'(DEPTH)) |-> !in_ready);

  p_stall_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !out_abort) |=> (out_valid && $stable(out_data)));

  if (WR_TXN) begin : g_wr
    p_hidden_r2: assert property (@(posedge clk) disable iff (rst)
      (!in_commit && !out_abort) |=> (out_used <= $past(out_used)));
    p_wr_abort_wins_r7: assert property (@(posedge clk) disable iff (rst)
      (in_abort && in_commit && !out_abort) |=> (out_used <= $past(out_used)));
  end

  if (RD_TXN) begin : g_rd
    p_space_kept_r5: assert property (@(posedge clk) disable iff (rst)
      (!out_commit && !in_abort) |=> (in_used >= $past(in_used)));
    p_rd_abort_wins_r7: assert property (@(posedge clk) disable iff (rst)
      (out_abort && out_commit && !in_abort) |=> (in_used >= $past(in_used)));
  end

endmodule

bind txn_fifo txn_fifo_chk #(.DEPTH(DEPTH), .DW(DW), .WR_TXN(WR_TXN), .RD_TXN(RD_TXN)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .in_commit(in_commit), .in_abort(in_abort),
  .in_used(in_used), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_commit(out_commit), .out_abort(out_abort), .out_used(out_used)
);

// File: tb/sim_txn_fifo.sv
`timescale 1ns/1ps
module sim_txn_fifo;
  localparam int DW = 16;
  localparam int D  = 5;
  localparam int UW = $clog2(D + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic in_valid = 1'b0, in_commit = 1'b0, in_abort = 1'b0;
  logic out_ready = 1'b0, out_commit = 1'b0, out_abort = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_data;
  logic [UW-1:0] in_used, out_used;

  int checks = 0, errors = 0, cyc = 0;

  txn_fifo #(.DW(DW), .DEPTH(D), .WR_TXN(1'b1), .RD_TXN(1'b1)) u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_commit(in_commit), .in_abort(in_abort), .in_used(in_used),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_commit(out_commit), .out_abort(out_abort), .out_used(out_used)
  );

  // Reference model: q holds words from the reader's committed point to the writer's tail.
  logic [DW-1:0] q[$];
  int wspec = 0, rspec = 0, vis = 0;
  bit m_push, m_pop;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      wspec = 0;
      rspec = 0;
    end else begin
      m_push = in_valid && (q.size() < D);
      vis    = q.size() - wspec;
      m_pop  = out_ready && (rspec < vis);
      if (m_push) in_data <= in_data + 1'b1;
      if (out_abort) rspec = 0;
      else begin
        if (m_pop) rspec++;
        if (out_commit) begin
          repeat (rspec) void'(q.pop_front());
          rspec = 0;
        end
      end
      if (in_abort) begin
        repeat (wspec) void'(q.pop_back());
        wspec = 0;
      end else begin
        if (m_push) begin
          q.push_back(in_data);
          wspec++;
        end
        if (in_commit) wspec = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int avail;
      avail = q.size() - wspec;
      check(in_ready == (q.size() < D), "R1 in_ready", in_ready, q.size() < D);
      check(out_valid == (rspec < avail), "R2 out_valid", out_valid, rspec < avail);
      if (rspec < avail)
        check(out_data == q[rspec], "R6 out_data order", out_data, q[rspec]);
      check(int'(in_used) == q.size(), "R8 in_used", in_used, q.size());
      check(int'(out_used) == avail - rspec, "R8 out_used", out_used, avail - rspec);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired, actual %0d expected below 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input bit v, input bit r, input bit wc, input bit wa, input bit rc, input bit ra);
    in_valid = v; out_ready = r; in_commit = wc; in_abort = wa; out_commit = rc; out_abort = ra;
    @(negedge clk);
  endtask

  task automatic run_pat(input logic [7:0] wp, input logic [7:0] rp, input int n);
    logic [7:0] a, b;
    a = wp; b = rp;
    for (int i = 0; i < n; i++) begin
      step(a[0], b[0], 1'b1, 1'b0, 1'b1, 1'b0);
      a = {a[0], a[7:1]};
      b = {b[0], b[7:1]};
    end
  endtask

  initial begin
    int first;
    bit saw_full, saw_empty;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
    check(in_used == '0 && out_used == '0, "R9 reset counts", in_used + out_used, 0);

    run_pat(8'hFF, 8'hFF, 40);
    run_pat(8'h5A, 8'hFF, 40);
    run_pat(8'hFF, 8'hA5, 40);
    saw_full = 1'b0;
    for (int i = 0; i < 6; i++) begin
      run_pat(8'hFD, 8'h11, 8);
      if (!in_ready) saw_full = 1'b1;
    end
    check(saw_full, "R1 overflow reaches full", saw_full, 1);
    saw_empty = 1'b0;
    for (int i = 0; i < 6; i++) begin
      run_pat(8'h11, 8'hFD, 8);
      if (!out_valid) saw_empty = 1'b1;
    end
    check(saw_empty, "R1 underflow reaches empty", saw_empty, 1);

    for (int i = 0; i < 3 * D; i++) step(0, 1, 1, 0, 1, 0);
    check(out_used == '0, "R1 drained", out_used, 0);

    for (int i = 0; i < D; i++) step(1, 0, 0, 0, 1, 0);
    check(out_valid == 1'b0, "R2 unpublished hidden", out_valid, 0);
    check(in_ready == 1'b0, "R3 full before abort", in_ready, 0);
    step(0, 0, 0, 1, 1, 0);
    check(in_ready == 1'b1, "R3 ready after abort", in_ready, 1);
    check(in_used == '0, "R3 words dropped", in_used, 0);

    first = in_data;
    for (int i = 0; i < D - 1; i++) step(1, 0, 0, 0, 1, 0);
    step(1, 0, 1, 0, 1, 0);
    check(int'(out_used) == D, "R4 last word published", out_used, D);
    check(int'(out_data) == first, "R4 head word", out_data, first);

    for (int i = 0; i < D; i++) step(0, 1, 1, 0, 0, 0);
    check(!out_valid && !in_ready, "R5 empty and full together", {out_valid, in_ready}, 0);
    check(int'(in_used) == D, "R5 space held", in_used, D);
    step(0, 0, 1, 0, 0, 1);
    check(int'(out_used) == D, "R6 rewind count", out_used, D);
    check(int'(out_data) == first, "R6 replay head", out_data, first);
    step(0, 1, 1, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    check(int'(out_data) == first + 2, "R6 replay order", out_data, first + 2);
    step(0, 0, 1, 0, 1, 1);
    check(int'(out_used) == D, "R7 read abort beats commit", out_used, D);
    check(int'(in_used) == D, "R7 no space released", in_used, D);
    for (int i = 0; i < D; i++) step(0, 1, 1, 0, 1, 0);
    check(in_used == '0 && in_ready, "R5 commit frees space", in_used, 0);
    step(1, 0, 1, 1, 1, 0);
    check(in_used == '0 && !out_valid, "R7 write abort beats commit", in_used, 0);

    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 1, 0);
    rst = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    rst = 1'b0;
    check(in_used == '0 && out_used == '0 && !out_valid && in_ready, "R9 reset mid-run",
          in_used + out_used, 0);

    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom;
      step(r[0] | r[1], r[2] | r[3], r[5:4] == 2'b00, r[9:6] == 4'b0000,
           r[11:10] == 2'b00, r[15:12] == 4'b0000);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule